// File: doc/BRIEF.md
# Dual-Band Programmable Divider Chain

This block brings the two digital oscillator feeds of a radio synthesizer down to the comparison frequency of its phase detector. It also divides a reference clock. All three inputs are slow square waves. A single fast sampling clock captures them, and every counter in the block runs on that clock.

The AM feed goes straight to the main divider. The FM feed first passes through a fixed divide-by-two prescaler. A band-select bit picks which of the two feeds drives the main divider. A second, independent divider counts reference edges, and its ratio sets the tuning step size.

Both dividers are 16 bits wide and take their ratios from control register inputs. Each divider emits a one-cycle pulse once per full division period.

Top module: `divchain_top`

## Requirements
- R1: The main divider emits one pulse for every `mainRatio` rising edges of its selected feed, and the reference divider emits one pulse for every `refRatio` rising edges of `refIn`. Both ratios are 16 bits, valid from 2 to 65535. With a steady feed of period P clocks, pulses are spaced ratio×P clocks apart.
- R2: The FM feed passes through a fixed divide-by-two before the band mux. With band FM, the main pulse spacing is 2×`mainRatio`×P clocks.
- R3: The AM feed reaches the mux with no prescaler. With band AM, the main pulse spacing is `mainRatio`×P clocks.
- R4: `bandSel`=0 selects the FM path and `bandSel`=1 selects the AM path. Edges on the path that is not selected have no effect on `mainPulse`.
- R5: A ratio of 0 or 1 is treated as a ratio of 2.
- R6: A new ratio takes effect only at the next terminal count. The period that is running when the ratio changes completes at the old ratio, and the following period uses the new one.
- R7: Every output pulse lasts exactly one clock cycle.
- R8: The reference divider runs independently of `bandSel` and of the oscillator feeds.
- R9: While `rst_n` is low (synchronous, active low), both outputs are 0 and the counters and the prescaler return to their start state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| amIn | input | 1 | AM oscillator feed (digital) |
| fmIn | input | 1 | FM oscillator feed (digital) |
| refIn | input | 1 | Reference oscillator feed (digital) |
| bandSel | input | 1 | 0 = FM path, 1 = AM path |
| mainRatio | input | 16 | Main divider ratio |
| refRatio | input | 16 | Reference divider ratio |
| mainPulse | output | 1 | One-cycle pulse at the divided main rate |
| refPulse | output | 1 | One-cycle pulse at the divided reference rate |

## Verification
The assertions assume that each feed stays high and low for at least one clock cycle, so that every rising edge survives the synchronizer as its own event. They also assume that `bandSel` is quasi-static: it changes only while the feeds are idle, so a change cannot land inside the pipeline between the edge detector and the strobe. The stimulus generates feeds with fixed even periods of four or six clocks and sets the band before it starts a feed. The ratio change is made well away from a terminal count, so the outcome of the old-or-new ratio rule is unambiguous.

// File: rtl/divchain_pkg.sv
package divchain_pkg;

  typedef enum logic {
    BAND_FM = 1'b0,
    BAND_AM = 1'b1
  } band_e;

  typedef struct packed {
    logic mainTick;
    logic refTick;
  } divStrobe_t;

  localparam int NUM_FEEDS = 3;
  localparam int FEED_AM   = 0;
  localparam int FEED_FM   = 1;
  localparam int FEED_REF  = 2;

endpackage

// File: rtl/divchain_ctrl.sv
module divchain_ctrl
  import divchain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       amIn,
  input  logic       fmIn,
  input  logic       refIn,
  input  logic       bandSel,
  output divStrobe_t strb
);

  logic [NUM_FEEDS-1:0] rawFeed;
  logic [NUM_FEEDS-1:0] syncA;
  logic [NUM_FEEDS-1:0] syncB;
  logic [NUM_FEEDS-1:0] history;
  logic [NUM_FEEDS-1:0] rise;
  logic                 prescPhase;
  logic                 fmTick;
  logic                 mainSel;

  assign rawFeed[FEED_AM]  = amIn;
  assign rawFeed[FEED_FM]  = fmIn;
  assign rawFeed[FEED_REF] = refIn;

  // two-flop synchronizer plus a history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA   <= '0;
      syncB   <= '0;
      history <= '0;
    end else begin
      syncA   <= rawFeed;
      syncB   <= syncA;
      history <= syncB;
    end
  end

  assign rise = syncB & ~history;

  // fixed divide-by-two on the FM path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prescPhase <= 1'b0;
    end else if (rise[FEED_FM]) begin
      prescPhase <= ~prescPhase;
    end
  end

  assign fmTick  = rise[FEED_FM] & prescPhase;
  assign mainSel = (band_e'(bandSel) == BAND_AM) ? rise[FEED_AM] : fmTick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb <= '0;
    end else begin
      strb.mainTick <= mainSel;
      strb.refTick  <= rise[FEED_REF];
    end
  end

  AST_PRESC_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise[FEED_FM] |=> (prescPhase != $past(prescPhase))); // R2

  AST_AM_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bandSel && rise[FEED_AM]) |=> strb.mainTick); // R3

  AST_BAND_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bandSel && !rise[FEED_AM]) |=> !strb.mainTick); // R4

  AST_REF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rise[FEED_REF] |=> strb.refTick); // R8

endmodule

// File: rtl/divchain_divider.sv
module divchain_divider #(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [RATIO_W-1:0] ratioIn,
  output logic               pulse
);

  localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(2);

  logic [RATIO_W-1:0] count;
  logic [RATIO_W-1:0] effRatio;
  logic [RATIO_W-1:0] ratioClamped;
  logic               terminal;

  assign ratioClamped = (ratioIn < MIN_RATIO) ? MIN_RATIO : ratioIn;
  assign terminal     = tick && (count == effRatio - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      effRatio <= ratioClamped;
      pulse    <= 1'b0;
    end else begin
      pulse <= terminal;
      if (terminal) begin
        count    <= '0;
        effRatio <= ratioClamped;
      end else if (tick) begin
        count <= count + RATIO_W'(1);
      end
    end
  end

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count < effRatio); // R1

  AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(tick)); // R1

  AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    effRatio >= MIN_RATIO); // R5

  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !terminal |=> $stable(effRatio)); // R6

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R7

endmodule

// File: rtl/divchain_datapath.sv
module divchain_datapath
  import divchain_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  divStrobe_t         strb,
  input  logic [RATIO_W-1:0] mainRatio,
  input  logic [RATIO_W-1:0] refRatio,
  output logic               mainPulse,
  output logic               refPulse
);

  localparam int NUM_DIV = 2;

  logic [NUM_DIV-1:0]              ticks;
  logic [NUM_DIV-1:0][RATIO_W-1:0] ratios;
  logic [NUM_DIV-1:0]              pulses;

  assign ticks[0]  = strb.mainTick;
  assign ticks[1]  = strb.refTick;
  assign ratios[0] = mainRatio;
  assign ratios[1] = refRatio;

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
    divchain_divider #(.RATIO_W(RATIO_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ticks[i]),
      .ratioIn (ratios[i]),
      .pulse   (pulses[i])
    );
  end

  assign mainPulse = pulses[0];
  assign refPulse  = pulses[1];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !$past(rst_n) |-> (!mainPulse && !refPulse)); // R9

endmodule

// File: rtl/divchain_top.sv
module divchain_top
  import divchain_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               amIn,
  input  logic               fmIn,
  input  logic               refIn,
  input  logic               bandSel,
  input  logic [RATIO_W-1:0] mainRatio,
  input  logic [RATIO_W-1:0] refRatio,
  output logic               mainPulse,
  output logic               refPulse
);

  divStrobe_t strb;

  divchain_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .amIn    (amIn),
    .fmIn    (fmIn),
    .refIn   (refIn),
    .bandSel (bandSel),
    .strb    (strb)
  );

  divchain_datapath #(.RATIO_W(RATIO_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .mainRatio (mainRatio),
    .refRatio  (refRatio),
    .mainPulse (mainPulse),
    .refPulse  (refPulse)
  );

endmodule

// File: tb/tb_divchain_top.sv
`timescale 1ns/1ps
module tb_divchain_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        amIn = 1'b0, fmIn = 1'b0, refIn = 1'b0;
  logic        bandSel = 1'b0;
  logic [15:0] mainRatio = 16'd4, refRatio = 16'd4;
  logic        mainPulse, refPulse;

  int checks = 0, fails = 0;
  bit amEn = 0, fmEn = 0, refEn = 0;
  int amHalf = 2, fmHalf = 2, refHalf = 3;

  int cyc = 0;
  int mainCount = 0, refCount = 0;
  int mainLast = 0, refLast = 0, mainIntv = 0, refIntv = 0;
  int widthErr = 0;
  logic prevMain = 0, prevRef = 0;

  divchain_top dut (
    .clk(clk), .rst_n(rst_n), .amIn(amIn), .fmIn(fmIn), .refIn(refIn),
    .bandSel(bandSel), .mainRatio(mainRatio), .refRatio(refRatio),
    .mainPulse(mainPulse), .refPulse(refPulse)
  );

  always #2.5 clk = ~clk;

  // feed generators, driven at the falling edge
  initial forever begin
    @(negedge clk);
    if (amEn) begin repeat (amHalf - 1) @(negedge clk); amIn = ~amIn; end
  end
  initial forever begin
    @(negedge clk);
    if (fmEn) begin repeat (fmHalf - 1) @(negedge clk); fmIn = ~fmIn; end
  end
  initial forever begin
    @(negedge clk);
    if (refEn) begin repeat (refHalf - 1) @(negedge clk); refIn = ~refIn; end
  end

  // output monitor, sampled at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (mainPulse) begin
      if (prevMain) widthErr++;
      mainCount++; mainIntv = cyc - mainLast; mainLast = cyc;
    end
    if (refPulse) begin
      if (prevRef) widthErr++;
      refCount++; refIntv = cyc - refLast; refLast = cyc;
    end
    prevMain = mainPulse;
    prevRef  = refPulse;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    amEn = 0; fmEn = 0; refEn = 0;
    @(negedge clk);
    amIn = 0; fmIn = 0; refIn = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    mainCount = 0; refCount = 0;
    rst_n = 1;
  endtask

  task automatic waitMain(int n);
    wait (mainCount >= n);
    @(negedge clk);
  endtask

  task automatic waitRef(int n);
    wait (refCount >= n);
    @(negedge clk);
  endtask

  task automatic testReset();
    rst_n = 0;
    amEn = 1; refEn = 1; bandSel = 1; mainRatio = 2; refRatio = 2;
    repeat (40) @(negedge clk);
    check("R9 main low in reset", mainCount, 0);
    check("R9 ref low in reset", refCount, 0);
    amEn = 0; refEn = 0;
  endtask

  task automatic testAm();
    bandSel = 1; mainRatio = 5; doReset();
    amHalf = 2; amEn = 1;
    waitMain(3);
    check("R3 AM spacing", mainIntv, 5 * 4);
  endtask

  task automatic testFm();
    bandSel = 0; mainRatio = 3; doReset();
    fmHalf = 2; fmEn = 1;
    waitMain(3);
    check("R2 FM spacing", mainIntv, 2 * 3 * 4);
  endtask

  task automatic testBandIgnore();
    bandSel = 1; mainRatio = 2; doReset();
    fmEn = 1;
    repeat (300) @(negedge clk);
    check("R4 FM ignored in AM band", mainCount, 0);
    bandSel = 0; doReset();
    amEn = 1;
    repeat (300) @(negedge clk);
    check("R4 AM ignored in FM band", mainCount, 0);
  endtask

  task automatic testRef();
    refRatio = 7; bandSel = 1; doReset();
    refHalf = 3; refEn = 1;
    waitRef(3);
    check("R1 ref spacing", refIntv, 7 * 6);
    bandSel = 0; doReset();
    refEn = 1; fmEn = 1;
    waitRef(3);
    check("R8 ref spacing other band", refIntv, 7 * 6);
  endtask

  task automatic testClamp();
    bandSel = 1; amHalf = 2; mainRatio = 0; doReset();
    amEn = 1;
    waitMain(3);
    check("R5 ratio 0 as 2", mainIntv, 2 * 4);
    mainRatio = 1; doReset();
    amEn = 1;
    waitMain(3);
    check("R5 ratio 1 as 2", mainIntv, 2 * 4);
  endtask

  task automatic testLarge();
    bandSel = 1; amHalf = 2; mainRatio = 300; doReset();
    amEn = 1;
    waitMain(3);
    check("R1 ratio 300 spacing", mainIntv, 300 * 4);
  endtask

  task automatic testChange();
    bandSel = 1; amHalf = 2; mainRatio = 5; doReset();
    amEn = 1;
    waitMain(2);
    repeat (6) @(negedge clk);
    mainRatio = 9;
    waitMain(3);
    check("R6 running period keeps old ratio", mainIntv, 5 * 4);
    waitMain(4);
    check("R6 next period uses new ratio", mainIntv, 9 * 4);
  endtask

  task automatic finish();
    check("R7 pulses one cycle wide", widthErr, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    testReset();
    testAm();
    testFm();
    testBandIgnore();
    testRef();
    testClamp();
    testLarge();
    testChange();
    check("R7 main count sane", (mainCount >= 4) ? 1 : 0, 1);
    finish();
  end

endmodule